// File: doc/BRIEF.md
# General-Purpose I/O Port with Falling-Edge Wake-up

This block is one 8-bit bidirectional I/O port as seen by a small processor core. For each pin it holds a direction bit and an output value latch. From the pad side it takes the raw input levels, and towards the pad it drives an output-enable and an output value for each pin. A third register holds one wake enable bit per pin. While the device sits in power-down, a high-to-low transition on any enabled pin raises a wake request. That request stays high until the power manager acknowledges the exit.

Pad levels cross into the clock domain through a synchroniser before the core reads them or the edge detector uses them. After reset every pin is an input and its output latch holds 1. Software that turns a pin into an output without first writing its value therefore sees that pin drive high. The register port is plain and has no handshake. A write lands on the next clock edge, and read data is combinational from the address. There is no data stream at the boundary, so there is no back-pressure to define. To change a single pin, software reads the whole byte, changes one bit and writes the whole byte back.

Top module: `gpio_wake_port`

## Requirements
- R1: During and after reset the output latch register and the direction register read 8'hFF, the wake enable register reads 8'h00, `pad_oe` is 8'h00 and `wake_req` is 0.
- R2: A direction bit of 1 makes that pin an input (`pad_oe` bit 0). A direction bit of 0 makes it an output (`pad_oe` bit 1). A byte write to the direction register sets all eight pins at the next clock edge.
- R3: `pad_out` always carries the output latch. A pin made an output with no prior data write drives 1.
- R4: `reg_addr` selects 0 = output latch / pin level, 1 = direction, 2 = wake enable, 3 = unused. Address 3 reads 8'h00, and a write to it changes nothing.
- R5: A read at address 0 returns, for each pin, the synchronised pad level if the pin is an input and the latch bit if it is an output. A pad change appears in that read after two rising clock edges.
- R6: When `powered_down` is 1, a 1-to-0 change of the synchronised level on a pin whose wake enable bit is 1 sets `wake_req` on the third rising edge after the pad change.
- R7: Rising edges, edges on pins whose wake enable bit is 0, and any edges while `powered_down` is 0 never set `wake_req`.
- R8: `wake_req` stays at 1 until a cycle with `wake_ack` at 1, after which it is 0 at the next edge. If a new wake event arrives in the same cycle as the acknowledge, the request stays set.
- R9: Writing back a byte read from a register with one bit changed alters only the pin that bit controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte for the selected register |
| pad_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Per-pin output enable (1 = drive) |
| pad_out | output | 8 | Per-pin output value |
| powered_down | input | 1 | Device is in power-down mode |
| wake_ack | input | 1 | Power-down exit acknowledge, clears the request |
| wake_req | output | 1 | Held wake request |

## Verification
On every cycle, the assertions check that register writes reach `pad_oe` and `pad_out` one edge later and that the outputs stay put when nothing is written. They also check that the unused address leaves all state alone, that a request holds until acknowledged, and that no request appears while the device is awake. The exact read-back mix of pad level and latch, the two-edge synchroniser latency, and the three-edge timing of a wake from one enabled pin can only be shown by the bench's scenarios. The same holds for the masking of disabled pins and rising edges. For these the bench runs a behavioural model every clock.

// File: rtl/gpio_wk_pkg.sv
package gpio_wk_pkg;
  typedef enum logic [1:0] {
    SEL_LATCH = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_WAKE  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_wk_sync.sv
module gpio_wk_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_wk_regs.sv
module gpio_wk_regs
  import gpio_wk_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  reg_sel_e     sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] wken_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '1;
      dir_q   <= '1;
      wken_q  <= '0;
    end else if (we) begin
      case (sel)
        SEL_LATCH: latch_q <= wdata;
        SEL_DIR:   dir_q   <= wdata;
        SEL_WAKE:  wken_q  <= wdata;
        default:   ;
      endcase
    end
  end

  // R4: the unused address never alters any register
  a_r4_unused_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_NONE) |=> ($stable(latch_q) && $stable(dir_q) && $stable(wken_q)));
endmodule

// File: rtl/gpio_wk_fall.sv
module gpio_wk_fall #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] enable,
  input  logic         powered_down,
  input  logic         ack,
  output logic         req
);
  logic [W-1:0] prev_q;
  logic [W-1:0] fell;
  logic         hit;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= level;
  end

  assign fell = prev_q & ~level & enable;
  assign hit  = powered_down && (|fell);

  always_ff @(posedge clk) begin
    if (!rst_n)   req <= 1'b0;
    else if (hit) req <= 1'b1;
    else if (ack) req <= 1'b0;
  end

  // R8: request holds without acknowledge
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> req);
  // R8: acknowledge while awake clears the request
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !powered_down) |=> !req);
  // R7: no request appears while the device is awake
  a_r7_awake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && !powered_down) |=> !req);
endmodule

// File: rtl/gpio_wake_port.sv
module gpio_wake_port
  import gpio_wk_pkg::*;
#(
  parameter int W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  input  logic         powered_down,
  input  logic         wake_ack,
  output logic         wake_req
);
  reg_sel_e     sel;
  logic [W-1:0] latch_q, dir_q, wken_q, pad_sync;

  assign sel = reg_sel_e'(reg_addr);

  gpio_wk_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(sel), .wdata(reg_wdata),
    .latch_q(latch_q), .dir_q(dir_q), .wken_q(wken_q)
  );

  gpio_wk_sync #(.W(W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
  );

  gpio_wk_fall #(.W(W)) u_fall (
    .clk(clk), .rst_n(rst_n), .level(pad_sync), .enable(wken_q),
    .powered_down(powered_down), .ack(wake_ack), .req(wake_req)
  );

  assign pad_oe  = ~dir_q;
  assign pad_out = latch_q;

  always_comb begin
    case (sel)
      SEL_LATCH: reg_rdata = (dir_q & pad_sync) | (~dir_q & latch_q);
      SEL_DIR:   reg_rdata = dir_q;
      SEL_WAKE:  reg_rdata = wken_q;
      default:   reg_rdata = '0;
    endcase
  end

  // R2: a direction write reaches the output enables one edge later, inverted
  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd1) |=> (pad_oe == ~$past(reg_wdata)));
  // R3: a latch write reaches the pad output one edge later
  a_r3_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd0) |=> (pad_out == $past(reg_wdata)));
  // R2, R3: pad controls stay put without a write
  a_r3_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

// File: tb/gpio_wake_port_test.sv
module gpio_wake_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [7:0] pad_in = 8'hFF;
  logic [7:0] pad_oe, pad_out;
  logic       powered_down = 1'b0;
  logic       wake_ack = 1'b0;
  logic       wake_req;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  gpio_wake_port uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .powered_down(powered_down),
    .wake_ack(wake_ack), .wake_req(wake_req)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model: pad history queue, newest first
  logic [7:0] m_latch = 8'hFF, m_dir = 8'hFF, m_wken = 8'h00;
  bit         m_wake = 0;
  logic [7:0] hist [$] = '{8'hFF, 8'hFF, 8'hFF};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_latch = 8'hFF; m_dir = 8'hFF; m_wken = 8'h00; m_wake = 0;
      hist = '{8'hFF, 8'hFF, 8'hFF};
    end else begin
      logic [7:0] f;
      f = hist[2] & ~hist[1] & m_wken;
      if (powered_down && (f != 8'h00)) m_wake = 1;
      else if (wake_ack) m_wake = 0;
      if (reg_we) begin
        if (reg_addr == 2'd0) m_latch = reg_wdata;
        else if (reg_addr == 2'd1) m_dir = reg_wdata;
        else if (reg_addr == 2'd2) m_wken = reg_wdata;
      end
      hist.push_front(pad_in);
      void'(hist.pop_back());
    end
  end

  function automatic logic [7:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return (m_dir & hist[1]) | (~m_dir & m_latch);
      2'd1: return m_dir;
      2'd2: return m_wken;
      default: return 8'h00;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      check(reg_addr == 0 ? "R5 read" : "R4 read", reg_rdata, model_read(reg_addr));
      check("R2 pad_oe", pad_oe, ~m_dir);
      check("R3 pad_out", pad_out, m_latch);
      check("R6/R7/R8 wake_req", {7'd0, wake_req}, {7'd0, m_wake});
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  initial begin
    #200000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] lf;
    step(3);
    // R1: reset state while reset held
    check("R1 pad_oe in reset", pad_oe, 8'h00);
    check("R1 wake_req in reset", {7'd0, wake_req}, 8'h00);
    rst_n = 1'b1;
    step();
    rd(2'd0, v); check("R1 latch/pin read", v, 8'hFF);
    rd(2'd1, v); check("R1 dir", v, 8'hFF);
    rd(2'd2, v); check("R1 wake enable", v, 8'h00);
    // R3: outputs drive high before any data write
    wr(2'd1, 8'hF0);
    check("R3 default high drive", pad_out, 8'hFF);
    check("R2 low nibble outputs", pad_oe, 8'h0F);
    // R5: mixed read
    wr(2'd0, 8'hA5);
    pad_in = 8'h3C;
    reg_addr = 2'd0;
    step();
    check("R5 before sync latency", reg_rdata, 8'hF5);
    step();
    check("R5 after two edges", reg_rdata, 8'h35);
    // R4: unused address
    wr(2'd3, 8'h12);
    rd(2'd3, v); check("R4 unused reads zero", v, 8'h00);
    check("R4 unused write ignored", pad_out, 8'hA5);
    // R9: read-modify-write of one direction bit
    rd(2'd1, v);
    wr(2'd1, v & 8'h7F);
    check("R9 only pin7 changes", pad_oe, 8'h8F);
    // R7: fall on disabled pin, and while awake
    wr(2'd2, 8'h81);
    pad_in = 8'hFF; step(4);
    pad_in = 8'hFE; step(4);
    check("R7 awake no wake", {7'd0, wake_req}, 8'h00);
    pad_in = 8'hFF; step(4);
    powered_down = 1'b1;
    pad_in = 8'hEF; step(4);
    check("R7 disabled pin", {7'd0, wake_req}, 8'h00);
    // R6: enabled pin falls, third edge
    pad_in = 8'hFF; step(4);
    pad_in = 8'hFE;
    step(2);
    check("R6 not yet after two edges", {7'd0, wake_req}, 8'h00);
    step();
    check("R6 set after three edges", {7'd0, wake_req}, 8'h01);
    // R7: rising edge does not re-trigger; R8 hold
    pad_in = 8'hFF; step(4);
    check("R8 held", {7'd0, wake_req}, 8'h01);
    wake_ack = 1'b1; step(); wake_ack = 1'b0;
    check("R8 cleared", {7'd0, wake_req}, 8'h00);
    step(4);
    check("R7 rising edge quiet", {7'd0, wake_req}, 8'h00);
    // R8: event coincides with ack
    pad_in = 8'h7F; step(2);
    wake_ack = 1'b1; step(); wake_ack = 1'b0;
    check("R8 set beats ack", {7'd0, wake_req}, 8'h01);
    wake_ack = 1'b1; powered_down = 1'b0; step(); wake_ack = 1'b0;
    // mixed traffic compared every clock by the model
    lf = 8'h5A;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      pad_in = lf ^ 8'h33;
      powered_down = lf[2];
      wake_ack = (lf[1:0] == 2'b11);
      reg_addr = lf[4:3];
      reg_we = (lf[7:5] == 3'b101);
      reg_wdata = lf ^ 8'hC6;
      step();
    end
    reg_we = 1'b0; wake_ack = 1'b0;
    step(2);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule